// File: doc/BRIEF.md
# Strobe-Mode Down Counter Channel

This block is one 16-bit binary down-counting channel of an interval timer. Its output line rests high and drops for exactly one clock when the count runs out. A mode write selects one of two ways to start a count. In software-start mode, loading an initial value is enough to start counting, and a low GATE level holds the count. In hardware-start mode, a load only stores the value, and each rising edge on GATE starts the count again from that stored value.

The initial value sits in a holding register. It moves into the counting element on the clock edge after the start condition, and it decrements on each enabled edge after that. A stored value of zero stands for 65536. After one strobe the channel stays quiet until it gets a new start. The reset input is asynchronous and active low, and its release is synchronised inside the block through a two-stage chain.

Top module: `strobe_down_counter`

## Requirements
- R1: After reset the output is high, and it stays high while nothing is loaded.
- R2: A mode write (`mode_wr_i`=1; `mode_hw_i`=0 selects software start, 1 selects hardware start) drives the output high on the next edge and cancels any count in progress. A load in the same cycle is discarded.
- R3: In software-start mode with GATE high, a load of N (1..65535) on clock edge E0 makes the output low during the period that follows edge E0+N+1.
- R4: The output is low for exactly one clock period per strobe.
- R5: In software-start mode, a load made while counting is transferred on the next edge and restarts timing: with the new value N' loaded on edge E, the strobe follows edge E+N'+1.
- R6: In software-start mode, each edge at which GATE is low (after the transfer) does not decrement, so it delays the strobe by one clock.
- R7: In hardware-start mode, a load alone starts nothing. A GATE rising edge at edge T (GATE high at T, low at the edge before T) gives the strobe after edge T+N+1, and GATE level after the trigger has no effect.
- R8: In hardware-start mode, a new GATE rising edge at edge T2 during counting restarts from the stored value, so the strobe follows edge T2+N+1.
- R9: A loaded value of 0 counts 65536, so the strobe follows edge E0+65537.
- R10: After a strobe, no further strobe occurs until a new load (software start) or trigger (hardware start).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_hw_i | input | 1 | Mode written: 0 software start, 1 hardware start |
| load_i | input | 1 | Count load strobe |
| count_i | input | 16 | Initial count value (0 means 65536) |
| gate_i | input | 1 | Gate: count enable in software mode, trigger in hardware mode |
| strobe_no | output | 1 | Active-low one-clock terminal-count strobe |

## Verification
Any wrong internal state shows up only as a strobe at the wrong edge, or as a strobe that is missing or repeated. The bench therefore counts edges from the load or trigger to the strobe and compares the count with the exact expected value. The error is visible within N+2 clocks of the start. A hold value that is not transferred, or a decrement that ignores GATE, shifts the strobe by at least one edge. A run flag that is never cleared produces a second strobe, which shows up within a later window of twenty quiet clocks.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic {
    SCD_SW = 1'b0,
    SCD_HW = 1'b1
  } scd_mode_e;
endpackage

// File: rtl/scd_rst_sync.sv
module scd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/scd_trig.sv
module scd_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;
  logic gate_d;

  always_comb gate_d = gate_i;

  // reset value 1: a level already high at reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_d;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/scd_cnt.sv
module scd_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             start_i,
  input  logic             dec_en_i,
  output logic             tc_o,
  output logic             run_o
);
  localparam int CW = CNT_W + 1;

  logic [CNT_W-1:0] hold_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             run_q, run_d;
  logic             xfer, dec, tc;

  always_comb begin
    xfer   = pend_q & ~clr_i;
    dec    = run_q & ~pend_q & ~clr_i & dec_en_i & (cnt_q != '0);
    tc     = dec & (cnt_q == CW'(1));
    pend_d = start_i & ~clr_i;
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (clr_i) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (xfer) begin
      cnt_d = {(hold_q == '0), hold_q};
      run_d = 1'b1;
    end else if (dec) begin
      cnt_d = cnt_q - CW'(1);
      if (tc) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (ld_i) hold_q <= val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      run_q  <= run_d;
    end
  end

  assign tc_o  = tc;
  assign run_o = run_q;
endmodule

// File: rtl/strobe_down_counter.sv
module strobe_down_counter
  import scd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic             mode_hw_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             gate_i,
  output logic             strobe_no
);
  logic      srst_n;
  logic      rise;
  logic      ld, start, dec_en, tc, run;
  logic      hw_mode;
  logic      strobe_q, strobe_d;
  scd_mode_e mode_q, mode_d;

  scd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  scd_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (srst_n),
    .gate_i (gate_i),
    .rise_o (rise)
  );

  always_comb begin
    hw_mode  = (mode_q == SCD_HW);
    ld       = load_i & ~mode_wr_i;
    start    = hw_mode ? rise : ld;
    dec_en   = hw_mode | gate_i;
    mode_d   = mode_wr_i ? scd_mode_e'(mode_hw_i) : mode_q;
    strobe_d = ~tc;
  end

  scd_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (srst_n),
    .clr_i    (mode_wr_i),
    .ld_i     (ld),
    .val_i    (count_i),
    .start_i  (start),
    .dec_en_i (dec_en),
    .tc_o     (tc),
    .run_o    (run)
  );

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      mode_q   <= SCD_SW;
      strobe_q <= 1'b1;
    end else begin
      mode_q   <= mode_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe_no = strobe_q;
endmodule

// File: rtl/scd_chk.sv
module scd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_wr_i,
  input logic gate_i,
  input logic hw_mode,
  input logic run,
  input logic strobe_no
);
  // R4
  strobe_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |=> strobe_no);

  // R2
  mode_wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (strobe_no && !run));

  // R6
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_mode && !gate_i) |=> strobe_no);

  // R10
  strobe_ends_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> !run);

  // R3
  strobe_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> $past(run));
endmodule

bind strobe_down_counter scd_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_wr_i (mode_wr_i),
  .gate_i    (gate_i),
  .hw_mode   (hw_mode),
  .run       (run),
  .strobe_no (strobe_no)
);

// File: tb/strobe_down_counter_tb_top.sv
`timescale 1ns/1ps
module strobe_down_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        mode_wr, mode_hw, load, gate;
  logic [15:0] count;
  logic        strobe_n;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  strobe_down_counter dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .mode_wr_i (mode_wr),
    .mode_hw_i (mode_hw),
    .load_i    (load),
    .count_i   (count),
    .gate_i    (gate),
    .strobe_no (strobe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input bit hw);
    mode_wr = 1'b1; mode_hw = hw;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic do_load(input int v);
    load = 1'b1; count = 16'(v);
    @(negedge clk);
    load = 1'b0;
  endtask

  // counts edges after E0 until strobe low; drives reloads and gate per edge
  task automatic measure(input int limit, input int rl_k, input int rl_v,
                         input int ga, input int gb, output int k);
    k = 0;
    forever begin
      gate = ((k + 1) >= ga && (k + 1) <= gb) ? 1'b0 : 1'b1;
      if ((k + 1) == rl_k) begin load = 1'b1; count = 16'(rl_v); end
      else load = 1'b0;
      @(negedge clk);
      k++;
      if (!strobe_n || k >= limit) break;
    end
    load = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!strobe_n) lows++;
    end
    chk(lows == 0, req, lows, 0);
  endtask

  task automatic t_reset;
    chk(strobe_n == 1'b1, "R1", strobe_n, 1);
    quiet(10, "R1");
  endtask

  task automatic t_sw_basic(input int n);
    int k;
    set_mode(1'b0);
    do_load(n);
    measure(n + 20, -1, 0, -1, -1, k);
    chk(k == n + 1, "R3", k, n + 1);
    @(negedge clk);
    chk(strobe_n == 1'b1, "R4", strobe_n, 1);
    quiet(20, "R10");
  endtask

  task automatic t_reload;
    int k;
    set_mode(1'b0);
    do_load(10);
    measure(40, 5, 3, -1, -1, k);
    chk(k == 9, "R5", k, 9);
    quiet(15, "R10");
  endtask

  task automatic t_gate;
    int k;
    set_mode(1'b0);
    do_load(5);
    measure(40, -1, 0, 3, 5, k);
    chk(k == 9, "R6", k, 9);
    gate = 1'b1;
    quiet(10, "R10");
  endtask

  task automatic t_modewr;
    set_mode(1'b0);
    do_load(8);
    repeat (3) @(negedge clk);
    set_mode(1'b0);
    chk(strobe_n == 1'b1, "R2", strobe_n, 1);
    quiet(20, "R2");
    load = 1'b1; count = 16'd2; mode_wr = 1'b1; mode_hw = 1'b0;
    @(negedge clk);
    load = 1'b0; mode_wr = 1'b0;
    quiet(10, "R2");
  endtask

  task automatic t_hw(input int n);
    int k;
    gate = 1'b0;
    set_mode(1'b1);
    do_load(n);
    quiet(12, "R7");
    gate = 1'b1;
    @(negedge clk);
    measure(n + 20, -1, 0, 2, 1000000, k);
    chk(k == n + 1, "R7", k, n + 1);
    @(negedge clk);
    chk(strobe_n == 1'b1, "R4", strobe_n, 1);
    quiet(15, "R10");
  endtask

  task automatic t_retrig;
    int k;
    gate = 1'b0;
    set_mode(1'b1);
    do_load(6);
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    measure(40, -1, 0, 4, 4, k);
    chk(k == 12, "R8", k, 12);
    quiet(15, "R10");
  endtask

  task automatic t_zero;
    int k;
    set_mode(1'b0);
    gate = 1'b1;
    do_load(0);
    measure(70000, -1, 0, -1, -1, k);
    chk(k == 65537, "R9", k, 65537);
  endtask

  initial begin
    rst_ni = 1'b0; mode_wr = 1'b0; mode_hw = 1'b0; load = 1'b0;
    gate = 1'b1; count = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sw_basic(1);
    t_sw_basic(7);
    t_reload();
    t_gate();
    t_modewr();
    t_hw(4);
    t_retrig();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule